// File: doc/BRIEF.md
# Manchester II Line Encoder with Command Sync

This block turns a serial NRZ bit stream into a pair of complementary Manchester II line signals. A single sample clock drives it. One bit cell lasts 16 or 32 sample clocks, as chosen by a speed input. The block gives out a 1X bit clock, and the data source uses it to present each new NRZ bit.

An active-low clear-to-send input gates the encoder. While clear-to-send is high, both line outputs rest high and the bit clock rests low. When clear-to-send goes from high to low, the encoder first sends a three-cell command sync. It then sends data cells back to back until clear-to-send is seen high at the end of a cell.

Top module: `manch_tx`

## Requirements
- R1: While no transmission is in progress (after reset, and after a transmission ends), `lineP` and `lineN` are both 1 and `bitClk` is 0.
- R2: A transmission starts only on a falling edge of `ctsN`, meaning `ctsN` is sampled 0 at a rising clock edge after being sampled 1 at the edge before it. The sync pattern appears at the outputs right after that edge. A reset leaves the previous sample at 1.
- R3: The command sync lasts three bit cells. `lineP` is 1 for the first 1.5 cells and 0 for the last 1.5 cells.
- R4: Data cells follow the sync with no gap. In each data cell, `lineP` carries the bit value for the first half of the cell and its complement for the second half.
- R5: During a transmission, `bitClk` is 1 in the first half of every cell and 0 in the second half. `nrzIn` is sampled at the clock edge where `bitClk` falls, and the sampled bit is sent in the next cell.
- R6: A cell is 16 clocks when `speedSel` is 0 and 32 clocks when it is 1. The value is taken when the transmission starts, and later changes of `speedSel` have no effect until the next start.
- R7: While a transmission is in progress, `lineN` is always the complement of `lineP`.
- R8: `ctsN` is checked only at the last clock of a cell. If it is high there, the outputs return to idle after that cell. A sync that has begun always completes all three cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| speedSel | input | 1 | Cell length select: 0 gives 16 clocks, 1 gives 32 clocks |
| ctsN | input | 1 | Clear to send, active low; a falling edge starts a transmission |
| nrzIn | input | 1 | Serial NRZ data, sampled when bitClk falls |
| lineP | output | 1 | Manchester line output, true phase |
| lineN | output | 1 | Manchester line output, complement phase |
| bitClk | output | 1 | 1X bit clock for the data source |

## Verification
Every output is decoded from registers only, so each result is due exactly one rising edge after the input sample that causes it. For example, the sync level appears one edge after `ctsN` is first sampled low. A bit sampled when `bitClk` falls shows up at the start of the following cell, half a cell later. A `ctsN` rise in the middle of a cell takes effect at that cell's last clock. The reference model advances at each rising edge, using inputs the bench drove at the previous falling edge. The bench compares the outputs against the model at every falling edge, so every due cycle is checked exactly where it falls. Targeted checks add the exact start edge, a 32-clock sync whose `speedSel` is changed mid-way, and a `ctsN` rise inside a data cell and inside the sync.

// File: rtl/manch_pkg.sv
package manch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } txState_t;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic active;     // a transmission is in progress
    logic inSync;     // current cell belongs to the command sync
    logic syncLevel;  // line level during the sync
    logic firstHalf;  // first half of the current cell
    logic capture;    // sample nrzIn (bitClk falls after this edge)
    logic load;       // last clock of a cell: move the sampled bit to the cell register
  } txStrobe_t;

endpackage

// File: rtl/manch_ctrl.sv
module manch_ctrl
  import manch_pkg::*;
#(
  parameter int SHORT_PERIOD = 16,
  parameter int LONG_PERIOD  = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      speedSel,
  input  logic      ctsN,
  output txStrobe_t strobe
);

  localparam int CNT_W = $clog2(LONG_PERIOD);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_PERIOD - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_PERIOD - 1);
  localparam logic [CNT_W-1:0] SHORT_HALF = CNT_W'(SHORT_PERIOD / 2);
  localparam logic [CNT_W-1:0] LONG_HALF  = CNT_W'(LONG_PERIOD / 2);
  localparam logic [1:0]       SYNC_LAST  = 2'd2;

  txState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       syncIdx;
  logic             perLong;
  logic             ctsPrev;

  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] halfCnt;
  logic             startTx;
  logic             cellEnd;

  always_comb begin
    lastCnt = perLong ? LONG_LAST : SHORT_LAST;
    halfCnt = perLong ? LONG_HALF : SHORT_HALF;
    startTx = (state == ST_IDLE) && ctsPrev && !ctsN;
    cellEnd = (state != ST_IDLE) && (cnt == lastCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      syncIdx <= '0;
      perLong <= 1'b0;
      ctsPrev <= 1'b1;
    end else begin
      ctsPrev <= ctsN;
      if (startTx) begin
        state   <= ST_SYNC;
        cnt     <= '0;
        syncIdx <= '0;
        perLong <= speedSel;
      end else if (state != ST_IDLE) begin
        if (cellEnd) begin
          cnt <= '0;
          if (state == ST_SYNC) begin
            if (syncIdx == SYNC_LAST) state <= ctsN ? ST_IDLE : ST_DATA;
            else                      syncIdx <= syncIdx + 2'd1;
          end else if (ctsN) begin
            state <= ST_IDLE;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.active    = (state != ST_IDLE);
    strobe.inSync    = (state == ST_SYNC);
    strobe.firstHalf = strobe.active && (cnt < halfCnt);
    strobe.syncLevel = (syncIdx == 2'd0) || ((syncIdx == 2'd1) && (cnt < halfCnt));
    strobe.capture   = strobe.active && (cnt == halfCnt - 1'b1);
    strobe.load      = cellEnd;
  end

  // A falling edge of ctsN seen while idle starts the sync at count zero
  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && ctsPrev && !ctsN) |=> (state == ST_SYNC && cnt == '0 && syncIdx == '0));

  // Leaving data mode happens only at the last clock of a cell
  assert_cell_boundary_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && cnt != lastCnt) |=> (state == ST_DATA));

  // The sync leaves its state only after its third cell
  assert_sync_length_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SYNC && !(syncIdx == SYNC_LAST && cnt == lastCnt)) |=> (state == ST_SYNC));

  // The cell length stays fixed for the whole transmission
  assert_speed_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(perLong));

endmodule

// File: rtl/manch_dp.sv
module manch_dp
  import manch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      nrzIn,
  input  txStrobe_t strobe,
  output logic      lineP,
  output logic      lineN,
  output logic      bitClk
);

  logic nextBit;
  logic dataBit;
  logic level;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextBit <= 1'b0;
      dataBit <= 1'b0;
    end else begin
      if (strobe.capture) nextBit <= nrzIn;
      if (strobe.load)    dataBit <= nextBit;
    end
  end

  always_comb begin
    if (strobe.inSync) level = strobe.syncLevel;
    else               level = strobe.firstHalf ? dataBit : !dataBit;
    lineP  = strobe.active ? level  : 1'b1;
    lineN  = strobe.active ? !level : 1'b1;
    bitClk = strobe.firstHalf;
  end

  assert_complement_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.active |-> (lineP != lineN));

  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |-> (lineP && lineN && !bitClk));

endmodule

// File: rtl/manch_tx.sv
module manch_tx
  import manch_pkg::*;
#(
  parameter int SHORT_PERIOD = 16,
  parameter int LONG_PERIOD  = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic speedSel,
  input  logic ctsN,
  input  logic nrzIn,
  output logic lineP,
  output logic lineN,
  output logic bitClk
);

  txStrobe_t strobe;

  manch_ctrl #(
    .SHORT_PERIOD(SHORT_PERIOD),
    .LONG_PERIOD (LONG_PERIOD)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .speedSel(speedSel),
    .ctsN    (ctsN),
    .strobe  (strobe)
  );

  manch_dp i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .nrzIn (nrzIn),
    .strobe(strobe),
    .lineP (lineP),
    .lineN (lineN),
    .bitClk(bitClk)
  );

endmodule

// File: tb/test_manch_tx.sv
`timescale 1ns/1ps
module test_manch_tx;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic speedSel = 1'b0;
  logic ctsN = 1'b1;
  logic nrzIn = 1'b0;
  logic lineP, lineN, bitClk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] cyc = '0;

  always #2.5 clk = ~clk;

  manch_tx i_manch_tx (
    .clk(clk), .rstN(rstN), .speedSel(speedSel), .ctsN(ctsN),
    .nrzIn(nrzIn), .lineP(lineP), .lineN(lineN), .bitClk(bitClk)
  );

  // Behavioural reference: 0 idle, 1 sync, 2 data
  int mState, mCnt, mIdx, mPer;
  logic mPend, mBit, mPrev;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mIdx = 0; mPer = 16;
      mPend = 0; mBit = 0; mPrev = 1;
    end else begin
      if (mState == 0) begin
        if (!ctsN && mPrev) begin
          mState = 1; mCnt = 0; mIdx = 0; mPer = speedSel ? 32 : 16;
        end
      end else begin
        if (mCnt == mPer / 2 - 1) mPend = nrzIn;
        if (mCnt == mPer - 1) begin
          mCnt = 0;
          mBit = mPend;
          if (mState == 1) begin
            if (mIdx == 2) mState = ctsN ? 0 : 2;
            else mIdx++;
          end else if (ctsN) begin
            mState = 0;
          end
        end else begin
          mCnt++;
        end
      end
      mPrev = ctsN;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    cyc <= cyc + 16'd1;
    if (rstN && !done) begin
      logic first, lvl;
      first = (mCnt < mPer / 2);
      if (mState == 0) begin
        chk(lineP, 1'b1, "R1", "idle lineP");
        chk(lineN, 1'b1, "R1", "idle lineN");
        chk(bitClk, 1'b0, "R1", "idle bitClk");
      end else begin
        if (mState == 1) begin
          lvl = (mIdx == 0) || (mIdx == 1 && first);
          chk(lineP, lvl, "R3", "sync lineP");
        end else begin
          lvl = first ? mBit : !mBit;
          chk(lineP, lvl, "R4", "data lineP");
        end
        chk(lineN, !lvl, "R7", "complement lineN");
        chk(bitClk, first, "R5", "bitClk phase");
      end
    end
  end

  // Data source: changing NRZ pattern
  always @(negedge clk) nrzIn <= cyc[3] ^ cyc[6] ^ cyc[1];

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    waitN(4);
    rstN = 1'b1;
    waitN(1);
    chk(lineP & lineN, 1'b1, "R1", "reset state lines");
    chk(bitClk, 1'b0, "R1", "reset state bitClk");
    waitN(20);

    // Frame A: short cells, stopped in the middle of a data cell
    ctsN = 1'b0;
    chk(lineN, 1'b1, "R2", "no start before edge");
    waitN(1);
    chk(lineN, 1'b0, "R2", "sync starts after edge");
    chk(bitClk, 1'b1, "R2", "bitClk starts after edge");
    waitN(180);
    ctsN = 1'b1;
    waitN(1);
    chk(lineP ^ lineN, 1'b1, "R8", "cell finishes after ctsN rise");
    waitN(40);
    chk(lineP & lineN, 1'b1, "R8", "idle after cell end");

    // Frame B: long cells, speedSel changed mid-transmission
    speedSel = 1'b1;
    waitN(3);
    ctsN = 1'b0;
    waitN(10);
    speedSel = 1'b0;
    waitN(31);
    chk(lineP, 1'b1, "R6", "long sync still high at position 40");
    waitN(3 * 32 + 4 * 32);
    ctsN = 1'b1;
    waitN(80);

    // Frame C: ctsN raised during the sync, sync must complete
    ctsN = 1'b0;
    waitN(20);
    ctsN = 1'b1;
    waitN(8);
    chk(lineP, 1'b0, "R8", "sync continues after ctsN rise");
    waitN(60);

    // Frame D: reset during a transmission, then restart
    ctsN = 1'b0;
    waitN(100);
    rstN = 1'b0;
    waitN(3);
    rstN = 1'b1;
    waitN(80);
    ctsN = 1'b1;
    waitN(60);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule